// File: doc/BRIEF.md
# Chained Active-Low Priority Encoder

This block turns a set of request lines into the binary index of the most important one. The most important line is the one with the highest index. Every pin is active low. A slice handles eight request lines and drives a three-bit code, a valid flag and an idle flag. The idle flag of one slice enables the slice below it, so slices can be stacked to cover a wider request set.

The top level stacks two slices to cover sixteen requests and produces a four-bit code. The most significant code bit says whether the upper slice is the one in charge. The three lower bits come from the active slice, formed by a bitwise AND of the two slices' active-low codes. The combined valid flag is low whenever either slice reports a request. The combined idle flag is the lower slice's idle flag. All paths are combinational.

Top module: `prio_enc_chain`

## Requirements
- R1: A request line is asserted when it is low. With exactly one line i low and the enable low, `code_n` equals the bitwise inverse of i as a four-bit number. For example, line 15 gives 0000 and line 0 gives 1111.
- R2: When several lines are low, only the highest-indexed one sets `code_n`. The state of every lower line has no effect on any output.
- R3: While `en_n` is high, `code_n` is 1111 and both `valid_n` and `idle_n` are high, whatever the request lines are.
- R4: With `en_n` low and no request line low, `code_n` is 1111, `valid_n` is high and `idle_n` is low.
- R5: `valid_n` is low exactly when `en_n` is low and at least one request line is low. This separates a request on line 0 (code 1111, `valid_n` low) from the idle state (code 1111, `valid_n` high).
- R6: Any low line among 8..15 takes precedence over every line among 0..7, and it drives `code_n[3]` low. When only lines among 0..7 are low, `code_n[3]` is high.
- R7: `idle_n` and `valid_n` are never low at the same time. `idle_n` is low only when the block is enabled and has no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_n | input | 16 | Request lines, active low; bit 15 has the highest priority |
| en_n | input | 1 | Enable, active low |
| code_n | output | 4 | Index of the winning request, active low |
| valid_n | output | 1 | Low when the code refers to a real request |
| idle_n | output | 1 | Low when enabled with no request; feeds the enable of a further stage |

## Verification
The bench targets line 0 against the idle case. Both give code 1111, so an encoder that lost the valid flag would report them the same way. It also walks each single line with the enable toggled. A design that ignored `en_n` would then show a code while disabled. A design that swapped the two flags would report idle while a request is pending. Random mixes with several lines low, including patterns that straddle the two slices, expose a chain wired the wrong way round: the lower slice would override the upper one, or the lower three code bits would come from the idle slice.

// File: rtl/prio_enc_pkg.sv
package prio_enc_pkg;
    localparam int unsigned SLICE_LINES = 8;
    localparam int unsigned SLICE_CODE  = $clog2(SLICE_LINES);
    localparam int unsigned NUM_SLICES  = 2;
endpackage

// File: rtl/prio_find_high.sv
// Locates the highest set bit of a positive-logic request vector.
module prio_find_high #(
    parameter int unsigned LINES = 8,
    localparam int unsigned IDX_W = $clog2(LINES)
) (
    input  logic [LINES-1:0] hit,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < LINES; i++) begin
            if (hit[i]) idx = IDX_W'(i);
        end
        any = |hit;
    end

    always_comb begin
        if (any) begin
            p_top_bit_r2: assert (hit[idx] && ((hit >> idx) == 1))
                else $error("finder index is not the highest set bit");
        end
    end
endmodule

// File: rtl/prio_enc_slice.sv
// One active-low priority encoder slice with enable chaining.
module prio_enc_slice #(
    parameter int unsigned LINES = prio_enc_pkg::SLICE_LINES,
    localparam int unsigned IDX_W = $clog2(LINES)
) (
    input  logic [LINES-1:0] req_n,
    input  logic             en_n,
    output logic [IDX_W-1:0] code_n,
    output logic             valid_n,
    output logic             idle_n
);
    logic [IDX_W-1:0] win_idx;
    logic             win_any;
    logic             active;

    prio_find_high #(.LINES(LINES)) find_i (
        .hit (~req_n),
        .idx (win_idx),
        .any (win_any)
    );

    assign active = ~en_n;

    always_comb begin
        code_n  = '1;
        valid_n = 1'b1;
        idle_n  = 1'b1;
        if (active) begin
            if (win_any) begin
                code_n  = ~win_idx;
                valid_n = 1'b0;
            end else begin
                idle_n  = 1'b0;
            end
        end
    end

    always_comb begin
        if (en_n) begin
            p_off_quiet_r3: assert (code_n == '1 && valid_n && idle_n)
                else $error("disabled slice drives an active output");
        end
        p_flags_excl_r7: assert (!(valid_n == 1'b0 && idle_n == 1'b0))
            else $error("valid and idle both asserted");
        if (!valid_n) begin
            p_code_hits_r5: assert (req_n[~code_n] == 1'b0)
                else $error("code points at an unasserted line");
        end
    end
endmodule

// File: rtl/prio_enc_chain.sv
// Two slices chained through the idle flag into a wider encoder.
module prio_enc_chain #(
    parameter int unsigned LINES = prio_enc_pkg::SLICE_LINES,
    localparam int unsigned NSL   = prio_enc_pkg::NUM_SLICES,
    localparam int unsigned IDX_W = $clog2(LINES),
    localparam int unsigned ALL   = LINES * NSL
) (
    input  logic [ALL-1:0]   req_n,
    input  logic             en_n,
    output logic [IDX_W:0]   code_n,
    output logic             valid_n,
    output logic             idle_n
);
    logic [NSL-1:0]   sl_en_n;
    logic [NSL-1:0]   sl_valid_n;
    logic [NSL-1:0]   sl_idle_n;
    logic [IDX_W-1:0] sl_code_n [NSL];

    // Slice NSL-1 holds the highest lines and sees the external enable.
    assign sl_en_n[NSL-1] = en_n;

    for (genvar s = 0; s < NSL; s++) begin : g_slice
        if (s < NSL - 1) begin : g_link
            assign sl_en_n[s] = sl_idle_n[s+1];
        end
        prio_enc_slice #(.LINES(LINES)) slice_i (
            .req_n   (req_n[s*LINES +: LINES]),
            .en_n    (sl_en_n[s]),
            .code_n  (sl_code_n[s]),
            .valid_n (sl_valid_n[s]),
            .idle_n  (sl_idle_n[s])
        );
    end

    assign code_n  = {sl_valid_n[1], sl_code_n[1] & sl_code_n[0]};
    assign valid_n = &sl_valid_n;
    assign idle_n  = sl_idle_n[0];

    always_comb begin
        if (!sl_valid_n[1]) begin
            p_upper_wins_r6: assert (sl_en_n[0] && sl_valid_n[0])
                else $error("lower slice active while upper slice has a request");
        end
        if (!valid_n) begin
            p_out_hits_r1: assert (req_n[~code_n] == 1'b0)
                else $error("combined code points at an unasserted line");
        end
    end
endmodule

// File: tb/prio_enc_chain_tb_top.sv
module prio_enc_chain_tb_top;
    localparam int unsigned N = 16;

    typedef struct {
        logic [3:0] code;
        logic       valid;
        logic       idle;
        string      tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_n = '1;
    logic         en_n = 1'b1;
    logic [3:0]   code_n;
    logic         valid_n;
    logic         idle_n;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    prio_enc_chain dut_i (
        .req_n   (req_n),
        .en_n    (en_n),
        .code_n  (code_n),
        .valid_n (valid_n),
        .idle_n  (idle_n)
    );

    function automatic exp_t model(input logic [N-1:0] r, input logic e);
        exp_t x;
        int top = -1;
        int cnt = 0;
        x.code = 4'hF; x.valid = 1'b1; x.idle = 1'b1; x.tag = "R3";
        for (int i = 0; i < N; i++) begin
            if (!r[i]) begin top = i; cnt++; end
        end
        if (!e) begin
            if (top < 0) begin
                x.idle = 1'b0; x.tag = "R4";
            end else begin
                x.code = ~4'(top); x.valid = 1'b0;
                if (cnt == 1) x.tag = "R1";
                else if (top >= 8 && r[7:0] != 8'hFF) x.tag = "R6";
                else x.tag = "R2";
            end
        end
        return x;
    endfunction

    task automatic drive(input logic [N-1:0] r, input logic e);
        @(posedge clk);
        #1;
        req_n = r;
        en_n  = e;
        sb_q.push_back(model(r, e));
    endtask

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b (req_n=%h en_n=%b)", tag, act, exp, req_n, en_n);
        end
    endtask

    // Monitor: pops one expected item per cycle and compares.
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.tag, code_n, e.code);
            check("R5", {3'b0, valid_n}, {3'b0, e.valid});
            check("R7", {3'b0, idle_n}, {3'b0, e.idle});
        end
    end

    initial begin
        // Reset state: disabled, so everything idles high (R3).
        #20;
        check("R3", {code_n[3:0]}, 4'hF);
        check("R3", {2'b0, valid_n, idle_n}, 4'b0011);
        rst_n = 1'b1;

        drive('1, 1'b0);                      // R4 idle
        drive(16'hFFFE, 1'b0);                // R5 line 0 versus idle
        for (int i = 0; i < N; i++) begin     // R1 every single line
            drive(~(16'h1 << i), 1'b0);
            drive(~(16'h1 << i), 1'b1);       // R3 disabled
        end
        drive(16'h0000, 1'b0);                // R2 all low
        drive(16'h0000, 1'b1);
        drive(16'h7F00, 1'b0);                // R6 line 15 plus all lower slice
        drive(16'hFE00, 1'b0);                // R6 lines 8..0 via straddle
        drive(16'hFF00, 1'b0);                // R2 only lower slice
        for (int k = 0; k < 300; k++) begin   // R2/R6 random mixes
            logic [N-1:0] r;
            r = 16'($urandom) | 16'($urandom);
            drive(r, k[2:0] == 3'd5);
        end
        repeat (3) @(posedge clk);
        done = 1'b1;
    end

    initial begin
        int ticks = 0;
        while (!done && ticks < 20000) begin
            @(posedge clk);
            ticks++;
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule